// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a processor core whose register namespace slides. A program always addresses 32 architectural registers by 5-bit number. Eight of them are global and shared by every procedure. The other 24 form a window onto a larger physical file, and a current-window pointer selects which window is visible. Neighbouring windows overlap, so a caller's outgoing argument registers become the callee's incoming registers without any copying.

The pointer moves only on explicit commands. A save request allocates a new window for a callee. A restore request returns to the caller's window. A trap request also allocates a fresh window for the handler. The physical file holds eight windows of sixteen private registers each, plus the globals. A window-invalid mask, supplied by supervisor software, marks windows that are reserved or still hold unspilled data. A move into a marked window is refused and raised as an overflow or underflow flag, so that software can spill or fill memory and retry. The file has two combinational read ports and one write port, which matches instructions that read two operands and write one result.

Top module: `wrf_regfile`

## Requirements
- R1: After reset `cur_win` is 0, both flags are low, and every architectural register reads as zero on both ports.
- R2: Register 0 always reads zero on both ports. A write to register 0 changes nothing.
- R3: Registers 1 to 7 are globals. A value written to a global reads back unchanged in every window, across any number of window moves.
- R4: Numbers 16 to 23 (locals) and 24 to 31 (ins) name storage private to the current window. Writes in one window are not visible through these numbers in any other window.
- R5: Numbers 8 to 15 (outs) of window w name the same storage as numbers 24 to 31 (ins) of window (w-1) mod 8. Out register 8+k is in register 24+k.
- R6: A save into a valid window sets the pointer to (w-1) mod 8, wrapping from 0 to 7. A restore into a valid window sets it to (w+1) mod 8, wrapping from 7 to 0. Both take effect at the next clock edge. With no command the pointer holds.
- R7: A trap request moves the pointer exactly as a save does. When several commands are raised in one cycle, trap or save takes priority over restore, and the pointer moves by a single step.
- R8: A save or trap whose target window has its bit set in `win_invalid` (bit n is window n) leaves the pointer unchanged. It raises `ovf_flag` for exactly the following cycle.
- R9: A restore whose target window is marked in `win_invalid` leaves the pointer unchanged. It raises `unf_flag` for exactly the following cycle and does not raise `ovf_flag`.
- R10: A write requested in the same cycle as a window command is addressed through the window that was current before the command. This holds whether or not the command is refused.
- R11: Reads are combinational. Both ports decode independently. A write becomes readable after the clock edge that performs it, and a read of the same register in the write cycle still returns the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, release synchronised inside |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_a_data | output | 32 | Read data, port A (combinational) |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_b_data | output | 32 | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | 32 | Write data |
| save_req | input | 1 | Allocate a new window (pointer minus one) |
| restore_req | input | 1 | Return to the previous window (pointer plus one) |
| trap_req | input | 1 | Allocate a fresh window for a trap handler |
| win_invalid | input | 8 | One bit per physical window, set when the window may not be entered |
| cur_win | output | 3 | Current window pointer |
| ovf_flag | output | 1 | One-cycle pulse: a save or trap was refused |
| unf_flag | output | 1 | One-cycle pulse: a restore was refused |

## Verification
The hardest situation to reach from the ports is the overlap seam. An out register written in one window must appear as an in register only in the window one step below, and this must hold across the wrap between window 0 and window 7. A refused command must leave the storage exactly as a plain write would. The stimulus first fills every register of window 0 with distinct values. It then saves across the wrap, issues writes together with accepted and refused commands, and finally runs a long pseudo-random mix of writes, commands and changing invalid masks. After every clock edge all 32 registers are swept on both ports against an arithmetic model of the window layout.

// File: rtl/wrf_pkg.sv
`timescale 1ns/1ps
package wrf_pkg;

  // Register group, decoded from the two top bits of an architectural number.
  typedef enum logic [1:0] {
    GRP_GLOBAL = 2'd0,
    GRP_OUT    = 2'd1,
    GRP_LOCAL  = 2'd2,
    GRP_IN     = 2'd3
  } reg_grp_e;

  // Resolved window command after priority.
  typedef enum logic [1:0] {
    WCMD_NONE    = 2'd0,
    WCMD_DOWN    = 2'd1,
    WCMD_UP      = 2'd2
  } win_cmd_e;

endpackage

// File: rtl/wrf_rst_sync.sv
`timescale 1ns/1ps
module wrf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_ns  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_ns  <= stage_q;
    end
  end

endmodule

// File: rtl/wrf_win_ctrl.sv
`timescale 1ns/1ps
module wrf_win_ctrl
  import wrf_pkg::*;
#(
  parameter  int NWIN = 8,
  localparam int WPW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            trap_req,
  input  logic [NWIN-1:0] win_invalid,
  output logic [WPW-1:0]  cwp,
  output logic            ovf,
  output logic            unf
);

  win_cmd_e       cmd;
  logic [WPW-1:0] dn_win;
  logic [WPW-1:0] up_win;
  logic [WPW-1:0] tgt_win;
  logic           tgt_bad;
  logic [WPW-1:0] cwp_nxt;
  logic           cwp_en;
  logic           ovf_nxt;
  logic           unf_nxt;

  // Next-state logic: priority, target window, legality.
  always_comb begin
    if (trap_req || save_req) begin
      cmd = WCMD_DOWN;
    end else if (restore_req) begin
      cmd = WCMD_UP;
    end else begin
      cmd = WCMD_NONE;
    end

    dn_win  = (cwp == '0) ? WPW'(NWIN - 1) : cwp - 1'b1;
    up_win  = (cwp == WPW'(NWIN - 1)) ? '0 : cwp + 1'b1;
    tgt_win = (cmd == WCMD_UP) ? up_win : dn_win;
    tgt_bad = win_invalid[tgt_win];

    cwp_nxt = cwp;
    cwp_en  = 1'b0;
    ovf_nxt = 1'b0;
    unf_nxt = 1'b0;
    unique case (cmd)
      WCMD_DOWN: begin
        if (tgt_bad) begin
          ovf_nxt = 1'b1;
        end else begin
          cwp_nxt = tgt_win;
          cwp_en  = 1'b1;
        end
      end
      WCMD_UP: begin
        if (tgt_bad) begin
          unf_nxt = 1'b1;
        end else begin
          cwp_nxt = tgt_win;
          cwp_en  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  // State registers.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cwp <= '0;
      ovf <= 1'b0;
      unf <= 1'b0;
    end else begin
      if (cwp_en) begin
        cwp <= cwp_nxt;
      end
      ovf <= ovf_nxt;
      unf <= unf_nxt;
    end
  end

  // An accepted save or trap steps the pointer down by one, modulo the window count.
  assert_save_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((save_req || trap_req) && !win_invalid[dn_win])
      |=> ((cwp + 1'b1) == $past(cwp)) && !ovf && !unf);

  // An accepted restore steps the pointer up by one.
  assert_restore_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !trap_req && !win_invalid[up_win])
      |=> (cwp == ($past(cwp) + 1'b1)) && !unf);

  // With no command the pointer holds and neither flag rises.
  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!save_req && !restore_req && !trap_req)
      |=> $stable(cwp) && !ovf && !unf);

  // A trap takes priority over a simultaneous restore.
  assert_trap_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_req && restore_req) |=> !unf);

  // A refused save or trap keeps the pointer and pulses the overflow flag.
  assert_no_overflow_move_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((save_req || trap_req) && win_invalid[dn_win])
      |=> ovf && $stable(cwp));

  // A refused restore keeps the pointer and pulses only the underflow flag.
  assert_no_underflow_move_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (restore_req && !save_req && !trap_req && win_invalid[up_win])
      |=> unf && !ovf && $stable(cwp));

endmodule

// File: rtl/wrf_addr_map.sv
`timescale 1ns/1ps
module wrf_addr_map
  import wrf_pkg::*;
#(
  parameter  int NWIN  = 8,
  parameter  int GRPSZ = 8,
  localparam int AW    = $clog2(4 * GRPSZ),
  localparam int OW    = $clog2(GRPSZ),
  localparam int WPW   = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int NPHYS = GRPSZ + NWIN * 2 * GRPSZ,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic [AW-1:0]  arch_idx,
  input  logic [WPW-1:0] cwp,
  output logic [PW-1:0]  phys_idx
);

  // Physical layout: globals first, then per window its locals followed by its ins.
  // The outs of a window are the ins of the window one step below.
  localparam int WSTRIDE = 2 * GRPSZ;

  reg_grp_e       grp;
  logic [OW-1:0]  off;
  logic [WPW-1:0] below;

  always_comb begin
    grp   = reg_grp_e'(arch_idx[AW-1 -: 2]);
    off   = arch_idx[OW-1:0];
    below = (cwp == '0) ? WPW'(NWIN - 1) : cwp - 1'b1;
    unique case (grp)
      GRP_GLOBAL: phys_idx = PW'(off);
      GRP_LOCAL:  phys_idx = PW'(GRPSZ + int'(cwp) * WSTRIDE + int'(off));
      GRP_IN:     phys_idx = PW'(GRPSZ + int'(cwp) * WSTRIDE + GRPSZ + int'(off));
      GRP_OUT:    phys_idx = PW'(GRPSZ + int'(below) * WSTRIDE + GRPSZ + int'(off));
      default:    phys_idx = '0;
    endcase
  end

endmodule

// File: rtl/wrf_store.sv
`timescale 1ns/1ps
module wrf_store #(
  parameter  int DW    = 32,
  parameter  int NPHYS = 136,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [PW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [PW-1:0] raddr_a,
  input  logic [PW-1:0] raddr_b,
  output logic [DW-1:0] rdata_a,
  output logic [DW-1:0] rdata_b
);

  logic [DW-1:0] mem [NPHYS];

  // Entry 0 backs the hard-wired zero register and has no storage.
  for (genvar i = 0; i < NPHYS; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign mem[i] = '0;
    end else begin : g_reg
      logic          hit;
      logic [DW-1:0] q;
      assign hit = we && (waddr == PW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          q <= '0;
        end else if (hit) begin
          q <= wdata;
        end
      end
      assign mem[i] = q;
    end
  end

  assign rdata_a = mem[raddr_a];
  assign rdata_b = mem[raddr_b];

  // A write to a real entry is held in that entry after the edge.
  assert_write_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (we && (waddr != '0)) |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/wrf_regfile.sv
`timescale 1ns/1ps
module wrf_regfile
  import wrf_pkg::*;
#(
  parameter  int DW    = 32,
  parameter  int NWIN  = 8,
  parameter  int GRPSZ = 8,
  localparam int AW    = $clog2(4 * GRPSZ),
  localparam int WPW   = (NWIN > 1) ? $clog2(NWIN) : 1,
  localparam int NPHYS = GRPSZ + NWIN * 2 * GRPSZ,
  localparam int PW    = $clog2(NPHYS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   rd_a_idx,
  output logic [DW-1:0]   rd_a_data,
  input  logic [AW-1:0]   rd_b_idx,
  output logic [DW-1:0]   rd_b_data,
  input  logic            wr_en,
  input  logic [AW-1:0]   wr_idx,
  input  logic [DW-1:0]   wr_data,
  input  logic            save_req,
  input  logic            restore_req,
  input  logic            trap_req,
  input  logic [NWIN-1:0] win_invalid,
  output logic [WPW-1:0]  cur_win,
  output logic            ovf_flag,
  output logic            unf_flag
);

  localparam int NPORT = 3;  // 0: write, 1: read A, 2: read B

  logic            rst_ns;
  logic [WPW-1:0]  cwp;
  logic [AW-1:0]   arch_sel [NPORT];
  logic [PW-1:0]   phys_sel [NPORT];
  logic            wr_ok;

  wrf_rst_sync u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ns (rst_ns)
  );

  wrf_win_ctrl #(
    .NWIN (NWIN)
  ) u_win_ctrl (
    .clk         (clk),
    .rst_n       (rst_ns),
    .save_req    (save_req),
    .restore_req (restore_req),
    .trap_req    (trap_req),
    .win_invalid (win_invalid),
    .cwp         (cwp),
    .ovf         (ovf_flag),
    .unf         (unf_flag)
  );

  assign arch_sel[0] = wr_idx;
  assign arch_sel[1] = rd_a_idx;
  assign arch_sel[2] = rd_b_idx;

  // Every port decodes through the pointer as it stands this cycle, so a
  // write issued with a shift lands in the pre-shift window.
  for (genvar p = 0; p < NPORT; p++) begin : g_map
    wrf_addr_map #(
      .NWIN  (NWIN),
      .GRPSZ (GRPSZ)
    ) u_map (
      .arch_idx (arch_sel[p]),
      .cwp      (cwp),
      .phys_idx (phys_sel[p])
    );
  end

  assign wr_ok = wr_en && (wr_idx != '0);

  wrf_store #(
    .DW    (DW),
    .NPHYS (NPHYS)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_ns),
    .we      (wr_ok),
    .waddr   (phys_sel[0]),
    .wdata   (wr_data),
    .raddr_a (phys_sel[1]),
    .raddr_b (phys_sel[2]),
    .rdata_a (rd_a_data),
    .rdata_b (rd_b_data)
  );

  assign cur_win = cwp;

  // Register 0 reads zero on both ports.
  assert_zero_reg_a_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_a_idx == '0) |-> (rd_a_data == '0));
  assert_zero_reg_b_R2: assert property (@(posedge clk) disable iff (!rst_ns)
    (rd_b_idx == '0) |-> (rd_b_data == '0));

  // A global keeps its value across window moves when nothing writes it.
  assert_global_shared_R3: assert property (@(posedge clk) disable iff (!rst_ns)
    ((rd_a_idx < AW'(GRPSZ)) && $stable(rd_a_idx) && !$past(wr_en))
      |-> $stable(rd_a_data));

  // Overflow and underflow never pulse together.
  assert_flags_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_ns)
    !(ovf_flag && unf_flag));

endmodule

// File: tb/wrf_regfile_tb.sv
`timescale 1ns/1ps
module wrf_regfile_tb;

  localparam int DW   = 32;
  localparam int NWIN = 8;
  localparam int G    = 8;
  localparam int NPH  = G + NWIN * 2 * G;

  logic            clk = 1'b0;
  logic            rst_n;
  logic [4:0]      rd_a_idx, rd_b_idx, wr_idx;
  logic [DW-1:0]   rd_a_data, rd_b_data, wr_data;
  logic            wr_en, save_req, restore_req, trap_req;
  logic [NWIN-1:0] win_invalid;
  logic [2:0]      cur_win;
  logic            ovf_flag, unf_flag;

  always #5 clk = ~clk;

  wrf_regfile u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_a_idx    (rd_a_idx),
    .rd_a_data   (rd_a_data),
    .rd_b_idx    (rd_b_idx),
    .rd_b_data   (rd_b_data),
    .wr_en       (wr_en),
    .wr_idx      (wr_idx),
    .wr_data     (wr_data),
    .save_req    (save_req),
    .restore_req (restore_req),
    .trap_req    (trap_req),
    .win_invalid (win_invalid),
    .cur_win     (cur_win),
    .ovf_flag    (ovf_flag),
    .unf_flag    (unf_flag)
  );

  int            n_chk = 0;
  int            n_err = 0;
  bit            done  = 0;
  logic [DW-1:0] m_mem [NPH];
  int            m_cw;
  logic [31:0]   lfsr;
  logic [7:0]    cur_mask;

  // Layout from R3 to R5: globals, then per window locals and ins; outs are ins one window down.
  function automatic int phys_of(int w, int r);
    int grp = r / 8;
    int off = r % 8;
    case (grp)
      0:       return off;
      1:       return G + ((w + NWIN - 1) % NWIN) * 2 * G + G + off;
      2:       return G + w * 2 * G + off;
      default: return G + w * 2 * G + G + off;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(int r);
    if (r == 0) return '0;
    return m_mem[phys_of(m_cw, r)];
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic sweep(string tag);
    for (int r = 0; r < 32; r++) begin
      rd_a_idx = 5'(r);
      rd_b_idx = 5'(31 - r);
      #1;
      chk(tag, $sformatf("port A reg %0d", r), rd_a_data, exp_rd(r));
      chk(tag, $sformatf("port B reg %0d", 31 - r), rd_b_data, exp_rd(31 - r));
    end
  endtask

  task automatic step(bit we, int idx, logic [31:0] d, bit sv, bit rs, bit tp,
                      logic [7:0] mask, string tag);
    bit eo, eu;
    int t;
    @(negedge clk);
    wr_en = we; wr_idx = 5'(idx); wr_data = d;
    save_req = sv; restore_req = rs; trap_req = tp;
    win_invalid = mask;
    rd_a_idx = 5'(idx);
    #1;
    // R11: the register being written still shows its old value before the edge
    chk("R11", "read in write cycle", rd_a_data, exp_rd(idx));
    @(posedge clk);
    #1;
    wr_en = 0; save_req = 0; restore_req = 0; trap_req = 0;
    if (we && idx != 0) m_mem[phys_of(m_cw, idx)] = d;
    eo = 0; eu = 0;
    if (tp || sv) begin
      t = (m_cw + NWIN - 1) % NWIN;
      if (mask[t]) eo = 1; else m_cw = t;
    end else if (rs) begin
      t = (m_cw + 1) % NWIN;
      if (mask[t]) eu = 1; else m_cw = t;
    end
    chk(tag, "cur_win", 32'(cur_win), 32'(m_cw));
    chk(tag, "ovf_flag", 32'(ovf_flag), 32'(eo));
    chk(tag, "unf_flag", 32'(unf_flag), 32'(eu));
    sweep(tag);
  endtask

  function automatic logic [31:0] nxt(logic [31:0] s);
    logic [31:0] x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; wr_en = 0; wr_idx = 0; wr_data = 0;
    save_req = 0; restore_req = 0; trap_req = 0; win_invalid = 0;
    rd_a_idx = 0; rd_b_idx = 0;
    for (int i = 0; i < NPH; i++) m_mem[i] = '0;
    m_cw = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "cur_win", 32'(cur_win), 32'd0);
    chk("R1", "ovf_flag", 32'(ovf_flag), 32'd0);
    chk("R1", "unf_flag", 32'(unf_flag), 32'd0);
    sweep("R1");

    // R2: writing register 0 is ignored
    step(1, 0, 32'hDEADBEEF, 0, 0, 0, 8'h00, "R2");
    // R3: globals
    for (int r = 1; r < 8; r++) step(1, r, 32'h6100_0000 + 32'(r), 0, 0, 0, 8'h00, "R3");
    // R4: fill outs, locals and ins of window 0
    for (int r = 8; r < 32; r++) step(1, r, 32'hA000_0000 + 32'(r * 3), 0, 0, 0, 8'h00, "R4");
    // R5: save across the wrap; ins of window 7 must show outs of window 0
    step(0, 0, 0, 1, 0, 0, 8'h00, "R5");
    step(1, 9, 32'h0B0B_0009, 0, 0, 0, 8'h00, "R5");
    step(1, 16, 32'h7777_0016, 0, 0, 0, 8'h00, "R4");
    // R10: write with an accepted save lands in the pre-shift window
    step(1, 17, 32'h1010_0017, 1, 0, 0, 8'h00, "R10");
    // R6: restores walking up through the wrap, saves walking back
    step(0, 0, 0, 0, 1, 0, 8'h00, "R6");
    step(0, 0, 0, 0, 1, 0, 8'h00, "R6");
    step(0, 0, 0, 0, 1, 0, 8'h00, "R6");
    step(0, 0, 0, 1, 0, 0, 8'h00, "R6");
    step(0, 0, 0, 1, 0, 0, 8'h00, "R6");
    step(0, 0, 0, 0, 0, 0, 8'h00, "R6");
    // R7: trap behaves as save and wins over restore
    step(0, 0, 0, 0, 0, 1, 8'h00, "R7");
    step(0, 0, 0, 0, 1, 1, 8'h00, "R7");
    step(0, 0, 0, 1, 1, 0, 8'h00, "R7");
    // R8: window 3 reserved; save and trap from window 4 refused
    step(0, 0, 0, 1, 0, 0, 8'h08, "R8");
    step(0, 0, 0, 0, 0, 1, 8'h08, "R8");
    step(0, 0, 0, 0, 0, 0, 8'h08, "R8");
    // R10: write together with a refused save
    step(1, 20, 32'h2020_0020, 1, 0, 0, 8'h08, "R10");
    // R9: window 5 reserved; restore from window 4 refused
    step(0, 0, 0, 0, 1, 0, 8'h20, "R9");
    step(1, 30, 32'h3030_0030, 0, 1, 0, 8'h20, "R9");
    // R3: globals unchanged after shifting back to window 0 and beyond
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 1, 0, 8'h00, "R3");

    // Mixed pseudo-random phase
    lfsr = 32'h1234_5678;
    cur_mask = 8'h00;
    for (int i = 0; i < 600; i++) begin
      logic [31:0] d;
      bit sv, rs, tp;
      lfsr = nxt(lfsr);
      d = nxt(lfsr);
      sv = 0; rs = 0; tp = 0;
      case (lfsr[9:7])
        3'd0: sv = 1;
        3'd1: rs = 1;
        3'd2: tp = 1;
        3'd3: begin tp = 1; rs = 1; end
        3'd4: rs = 1;
        default: ;
      endcase
      if (lfsr[12:10] == 3'd0) cur_mask = 8'(1 << lfsr[15:13]);
      else if (lfsr[12:10] == 3'd1) cur_mask = 8'h00;
      step(lfsr[0] | lfsr[1], int'(lfsr[6:2]), d, sv, rs, tp, cur_mask, "R4");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule